// File: doc/BRIEF.md
# Per-Pin Drive Waveform Shaper

This block shapes the drive of one tester channel. A stream of vectors arrives over a valid/ready handshake. Each vector carries one data bit and one drive-enable bit. Every accepted vector occupies one vector period of a programmable number of master clock ticks. Inside that period, two programmable offsets (lead and trail, counted in ticks from the start of the period) place the edges of the waveform. A format code selects how the data bit and the two edges combine. Non-return holds the data for the whole period and switches to the new value at the lead edge. Return-to-zero rests at 0 and shows the data between the edges. Return-to-one rests at 1 and shows the data between the edges. So the same data sequence gives a different pin waveform for each timing set or format.

Timing is written into a shadow set through a write strobe. The shadow set is copied into the active set only when a vector is accepted, so a write never disturbs a period that is already running. A timing set with impossible edges is reported and treated as a flat level. A vector with its drive bit clear releases the pin for that period. When no vector is ready at a period boundary, the channel goes idle and releases the pin.

The control is a two-state machine. ST_IDLE means no period is running: the pin is released and the block is ready. ST_RUN means a period is in progress. The transitions are: ST_IDLE to ST_RUN on an accepted vector; ST_RUN to ST_RUN at the last tick of a period when a new vector is accepted; ST_RUN to ST_IDLE at the last tick when no vector is offered; ST_RUN holds on every other tick.

Top module: `pin_wavegen`

## Requirements
- R1: After reset the block is idle: pin_oe=0, pin_level=0, cfg_err=0, vec_ready=1. The timing set is period 4, lead 0, trail 2, format 0, and the previous-data bit is 0.
- R2: vec_ready is 1 while idle and in the last tick of a running period, and 0 otherwise. An accepted vector (vec_valid and vec_ready at a clock edge) begins its period at tick 0 in the cycle after that edge.
- R3: With vectors offered back to back, every period lasts exactly cfg_period ticks (ticks 0 to period-1), where a period value of 0 means 2^W ticks.
- R4: Format 0 (non-return): in ticks below lead the pin shows the previous accepted vector's data bit, and from tick lead onward it shows the current data bit.
- R5: Format 1 (return-to-zero): the pin shows the data bit in ticks t with lead <= t < trail, and 0 in all other ticks.
- R6: Format 2 (return-to-one): the pin shows the data bit in ticks t with lead <= t < trail, and 1 in all other ticks.
- R7: Format code 3 behaves exactly like format 0.
- R8: If lead >= trail or trail >= period in the active set, cfg_err is 1 for the whole of that period, and the driven pin shows the current data bit in every tick, whatever the format.
- R9: A vector with vec_drive=0 gives pin_oe=0 and pin_level=0 for its whole period. Its data bit still becomes the previous-data bit of the next vector.
- R10: When no vector is accepted at the last tick of a period, the block is idle from the next cycle, with pin_oe=0, pin_level=0 and cfg_err=0, until a vector is accepted.
- R11: cfg_wr copies cfg_period, cfg_lead, cfg_trail and cfg_fmt into a shadow set. The active set takes the shadow value only at a vector acceptance. A write in the same cycle as an acceptance applies from the vector after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the shadow timing set |
| cfg_period | input | W | Period length in ticks |
| cfg_lead | input | W | Lead edge offset in ticks |
| cfg_trail | input | W | Trail edge offset in ticks |
| cfg_fmt | input | 2 | Format: 0 non-return, 1 return-to-zero, 2 return-to-one, 3 as 0 |
| vec_valid | input | 1 | A vector is offered |
| vec_ready | output | 1 | The block takes the offered vector at this edge |
| vec_data | input | 1 | Pin data bit of the vector |
| vec_drive | input | 1 | 1 drives the pin in this vector's period, 0 releases it |
| pin_level | output | 1 | Level to drive onto the pin |
| pin_oe | output | 1 | Drive enable of the pin |
| cfg_err | output | 1 | The running period uses an invalid timing set |

## Verification
All outputs are decoded from registered state. vec_ready changes in the same cycle as the state it reflects, and pin_level, pin_oe and cfg_err show tick 0 of a new period in the cycle right after the accepting edge. The bench keeps a behavioural model of the tick, the active and shadow timing sets and the data history. It compares all four outputs at every falling edge. It then advances the model with the inputs that the next rising edge will sample, so a result is never sampled one cycle early or one cycle late. The stimulus covers a (1,0,1,0) pattern under each format, invalid timing sets, released vectors, gaps and timing writes placed inside running periods.

// File: rtl/pintg_pkg.sv
package pintg_pkg;

    typedef enum logic [1:0] {
        FMT_NR     = 2'd0,
        FMT_RZ     = 2'd1,
        FMT_RO     = 2'd2,
        FMT_NR_ALT = 2'd3
    } fmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;

endpackage

// File: rtl/pintg_period_ctr.sv
module pintg_period_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         advance,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         last
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (advance)
            cnt <= cnt + ONE;
    end

    assign last = (cnt == (period - ONE));
endmodule

// File: rtl/pintg_timing_regs.sv
module pintg_timing_regs
    import pintg_pkg::*;
#(
    parameter int W = 8,
    parameter logic [W-1:0] RST_PERIOD = W'(4),
    parameter logic [W-1:0] RST_LEAD   = W'(0),
    parameter logic [W-1:0] RST_TRAIL  = W'(2)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_period,
    input  logic [W-1:0] wr_lead,
    input  logic [W-1:0] wr_trail,
    input  fmt_e         wr_fmt,
    input  logic         load,
    output logic [W-1:0] act_period,
    output logic [W-1:0] act_lead,
    output logic [W-1:0] act_trail,
    output fmt_e         act_fmt,
    output logic         act_bad
);
    logic [W-1:0] sh_period, sh_lead, sh_trail;
    fmt_e         sh_fmt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_period <= RST_PERIOD;
            sh_lead   <= RST_LEAD;
            sh_trail  <= RST_TRAIL;
            sh_fmt    <= FMT_NR;
        end else if (wr_en) begin
            sh_period <= wr_period;
            sh_lead   <= wr_lead;
            sh_trail  <= wr_trail;
            sh_fmt    <= wr_fmt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_period <= RST_PERIOD;
            act_lead   <= RST_LEAD;
            act_trail  <= RST_TRAIL;
            act_fmt    <= FMT_NR;
        end else if (load) begin
            act_period <= sh_period;
            act_lead   <= sh_lead;
            act_trail  <= sh_trail;
            act_fmt    <= sh_fmt;
        end
    end

    assign act_bad = (act_lead >= act_trail) || (act_trail >= act_period);
endmodule

// File: rtl/pintg_formatter.sv
module pintg_formatter
    import pintg_pkg::*;
#(
    parameter int W = 8
) (
    input  fmt_e         fmt,
    input  logic [W-1:0] lead,
    input  logic [W-1:0] trail,
    input  logic [W-1:0] tick,
    input  logic         bad,
    input  logic         data,
    input  logic         prev,
    output logic         level
);
    logic in_win;

    assign in_win = (tick >= lead) && (tick < trail);

    always_comb begin
        if (bad) begin
            level = data;
        end else begin
            unique case (fmt)
                FMT_RZ:  level = in_win ? data : 1'b0;
                FMT_RO:  level = in_win ? data : 1'b1;
                default: level = (tick < lead) ? prev : data;
            endcase
        end
    end
endmodule

// File: rtl/pin_wavegen.sv
module pin_wavegen
    import pintg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_period,
    input  logic [W-1:0] cfg_lead,
    input  logic [W-1:0] cfg_trail,
    input  logic [1:0]   cfg_fmt,
    input  logic         vec_valid,
    output logic         vec_ready,
    input  logic         vec_data,
    input  logic         vec_drive,
    output logic         pin_level,
    output logic         pin_oe,
    output logic         cfg_err
);
    run_e         state, state_nx;
    logic [W-1:0] cnt;
    logic         last;
    logic         accept;
    logic [W-1:0] act_period, act_lead, act_trail;
    fmt_e         act_fmt;
    logic         act_bad;
    logic         cur_data, prev_data, cur_drive;
    logic         shaped;

    assign accept = vec_valid && vec_ready;

    pintg_period_ctr #(.W(W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .advance (state == ST_RUN),
        .period  (act_period),
        .cnt     (cnt),
        .last    (last)
    );

    pintg_timing_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr),
        .wr_period  (cfg_period),
        .wr_lead    (cfg_lead),
        .wr_trail   (cfg_trail),
        .wr_fmt     (fmt_e'(cfg_fmt)),
        .load       (accept),
        .act_period (act_period),
        .act_lead   (act_lead),
        .act_trail  (act_trail),
        .act_fmt    (act_fmt),
        .act_bad    (act_bad)
    );

    pintg_formatter #(.W(W)) u_fmt (
        .fmt   (act_fmt),
        .lead  (act_lead),
        .trail (act_trail),
        .tick  (cnt),
        .bad   (act_bad),
        .data  (cur_data),
        .prev  (prev_data),
        .level (shaped)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_data  <= 1'b0;
            prev_data <= 1'b0;
            cur_drive <= 1'b0;
        end else if (accept) begin
            cur_data  <= vec_data;
            prev_data <= cur_data;
            cur_drive <= vec_drive;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (vec_valid) state_nx = ST_RUN;
            ST_RUN:  if (last && !vec_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        vec_ready = 1'b0;
        pin_oe    = 1'b0;
        pin_level = 1'b0;
        cfg_err   = 1'b0;
        unique case (state)
            ST_IDLE: vec_ready = 1'b1;
            ST_RUN: begin
                vec_ready = last;
                pin_oe    = cur_drive;
                pin_level = cur_drive & shaped;
                cfg_err   = act_bad;
            end
            default: vec_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/pin_wavegen_chk.sv
module pin_wavegen_chk
    import pintg_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         vec_valid,
    input logic         vec_ready,
    input logic         pin_level,
    input logic         pin_oe,
    input logic         cfg_err,
    input run_e         state,
    input logic [W-1:0] cnt,
    input logic [W-1:0] act_lead,
    input logic [W-1:0] act_trail,
    input fmt_e         act_fmt,
    input logic         cur_data
);
    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_ready) |=> (cnt == '0 && state == ST_RUN)); // R2

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !vec_ready) |=> (cnt == W'($past(cnt) + 1'b1))); // R3

    AST_RZ_REST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && !cfg_err && act_fmt == FMT_RZ && cnt < act_lead) |-> !pin_level); // R5

    AST_RO_REST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && !cfg_err && act_fmt == FMT_RO && cnt >= act_trail) |-> pin_level); // R6

    AST_ERR_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && pin_oe) |-> (pin_level == cur_data)); // R8

    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_level); // R9

    AST_GAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ready && !vec_valid) |=> (!pin_oe && !cfg_err && vec_ready)); // R10

    AST_TIMING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && vec_ready) |=> ($stable(act_lead) && $stable(act_trail) && $stable(act_fmt))); // R11
endmodule

bind pin_wavegen pin_wavegen_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_valid (vec_valid),
    .vec_ready (vec_ready),
    .pin_level (pin_level),
    .pin_oe    (pin_oe),
    .cfg_err   (cfg_err),
    .state     (state),
    .cnt       (cnt),
    .act_lead  (act_lead),
    .act_trail (act_trail),
    .act_fmt   (act_fmt),
    .cur_data  (cur_data)
);

// File: tb/pin_wavegen_bench.sv
module pin_wavegen_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [W-1:0] cfg_period = '0, cfg_lead = '0, cfg_trail = '0;
    logic [1:0]   cfg_fmt = '0;
    logic         vec_valid = 1'b0, vec_data = 1'b0, vec_drive = 1'b0;
    logic         vec_ready, pin_level, pin_oe, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pin_wavegen #(.W(W)) u_pin_wavegen (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
        .cfg_lead(cfg_lead), .cfg_trail(cfg_trail), .cfg_fmt(cfg_fmt),
        .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
        .vec_drive(vec_drive), .pin_level(pin_level), .pin_oe(pin_oe),
        .cfg_err(cfg_err)
    );

    // behavioural reference state
    int m_run, m_cnt, m_data, m_prev, m_drive, m_first;
    int a_p, a_l, a_t, a_f;
    int s_p, s_l, s_t, s_f;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_data = 0; m_prev = 0; m_drive = 0; m_first = 1;
            a_p = 4; a_l = 0; a_t = 2; a_f = 0;   // R1 reset timing set
            s_p = 4; s_l = 0; s_t = 2; s_f = 0;
        end else if (!done) begin
            int  last_tick;
            int  ready, bad, win, oe, err, lvl, acc;
            string tg;
            last_tick = (a_p + 255) % 256;
            ready = (!m_run || m_cnt == last_tick) ? 1 : 0;
            bad   = (a_l >= a_t || a_t >= a_p) ? 1 : 0;
            win   = (m_cnt >= a_l && m_cnt < a_t) ? 1 : 0;
            oe    = (m_run && m_drive) ? 1 : 0;
            err   = (m_run && bad) ? 1 : 0;
            if (!oe)            lvl = 0;
            else if (bad)       lvl = m_data;
            else if (a_f == 1)  lvl = win ? m_data : 0;
            else if (a_f == 2)  lvl = win ? m_data : 1;
            else                lvl = (m_cnt < a_l) ? m_prev : m_data;

            if (m_first)                                    tg = "R1";
            else if (!m_run)                                tg = "R10";
            else if (bad)                                   tg = "R8";
            else if (!m_drive)                              tg = "R9";
            else if (s_p != a_p || s_l != a_l || s_t != a_t || s_f != a_f) tg = "R11";
            else if (a_f == 3)                              tg = "R7";
            else if (a_f == 1)                              tg = "R5";
            else if (a_f == 2)                              tg = "R6";
            else                                            tg = "R4";
            m_first = 0;

            chk(tg, "pin_level", int'(pin_level), lvl);
            chk(tg, "pin_oe", int'(pin_oe), oe);
            chk(tg, "cfg_err", int'(cfg_err), err);
            chk(tg == "R1" ? "R1" : (m_run ? "R3" : "R2"), "vec_ready", int'(vec_ready), ready);

            // advance to the state after the coming rising edge
            acc = (vec_valid && ready) ? 1 : 0;
            if (acc) begin
                a_p = s_p; a_l = s_l; a_t = s_t; a_f = s_f;
                m_prev = m_data; m_data = int'(vec_data); m_drive = int'(vec_drive);
                m_cnt = 0; m_run = 1;
            end else if (m_run && ready) begin
                m_run = 0;
            end else if (m_run) begin
                m_cnt = (m_cnt + 1) % 256;
            end
            if (cfg_wr) begin
                s_p = int'(cfg_period); s_l = int'(cfg_lead);
                s_t = int'(cfg_trail);  s_f = int'(cfg_fmt);
            end
        end
    end

    task automatic cfg(int p, int l, int t, int f);
        cfg_wr = 1'b1;
        cfg_period = W'(p); cfg_lead = W'(l); cfg_trail = W'(t); cfg_fmt = 2'(f);
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic send(bit d, bit drv);
        vec_valid = 1'b1; vec_data = d; vec_drive = drv;
        forever begin
            @(negedge clk);
            if (vec_ready) break;
        end
        @(posedge clk); #1;
        vec_valid = 1'b0;
        cfg_wr = 1'b0;
    endtask

    task automatic gap(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        gap(2);
        // same 1,0,1,0 data under each format: R4 R5 R6
        cfg(10, 3, 7, 0);
        send(1, 1); send(0, 1); send(1, 1); send(0, 1);
        cfg(10, 3, 7, 1);                      // R11: written mid-period
        send(1, 1); send(0, 1); send(1, 1); send(0, 1);
        cfg(10, 3, 7, 2);
        send(1, 1); send(0, 1); send(1, 1); send(0, 1);
        cfg(9, 2, 8, 3);                       // R7
        send(1, 1); send(0, 1); send(1, 1);
        cfg(10, 5, 5, 1);                      // R8 lead == trail
        send(0, 1); send(1, 1);
        cfg(10, 2, 10, 2);                     // R8 trail at period
        send(0, 1); send(1, 1);
        cfg(6, 1, 4, 2);                       // R9 released vectors
        send(0, 0); send(1, 0); send(0, 1);
        gap(7);                                // R10 idle
        cfg(2, 0, 1, 1);                       // shortest legal period
        send(1, 1); send(1, 1); send(0, 1);
        gap(3);
        for (int i = 0; i < 300; i++) begin
            int p;
            p = 2 + int'($urandom % 11);
            if ($urandom % 4 == 0)
                cfg(p, int'($urandom % (p + 1)), int'($urandom % (p + 2)), int'($urandom % 4));
            if ($urandom % 5 == 0) begin   // write held through acceptance
                cfg_wr = 1'b1;
                cfg_period = W'(p); cfg_lead = W'($urandom % p);
                cfg_trail = W'(p - 1); cfg_fmt = 2'($urandom % 4);
            end
            send(1'($urandom), ($urandom % 6) != 0);
            if ($urandom % 8 == 0) gap(int'($urandom % 15));
        end
        gap(15);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule